// File: doc/BRIEF.md
# Dual-Channel Waveform Compare Timer

An 8-bit up/down counter drives two compare channels, A and B. Each channel has a compare register and an output flip-flop. A 3-bit wave code picks how the counter runs and where its TOP lies: free-running, clear-on-compare, single-slope PWM or dual-slope PWM. A 2-bit action field per channel decides what the flip-flop does on a compare hit, at the counter wrap and on each slope of the dual-slope ramp.

When a channel's action field connects it, the channel's flip-flop value drives the pin. Otherwise the pin carries the plain port data bit. The driver enable of each pin always follows its direction bit.

In the PWM codes the compare registers are double-buffered, so a new duty value takes effect only at the counter's turning point.

Top module: `tc_pwm_unit`

## Requirements
- R1: After reset the counter is 0 and counting up, both compare registers (buffer and active) are 0, both output flip-flops are 0, the wave code is 000 and both action fields are 00.
- R2: `pin_oe[0]` equals `port_dir[0]` and `pin_oe[1]` equals `port_dir[1]` at all times. A channel whose action field is 00 shows its port data bit (bit 0 for A, bit 1 for B) on its pin in the same cycle.
- R3: The wave codes are as follows.
  - 000, 100 and 110 are free-running, with TOP = 0xFF.
  - 010 is clear-on-compare, with TOP = compare A.
  - 011 is single-slope PWM with TOP = 0xFF, and 111 is single-slope PWM with TOP = compare A.
  - 001 is dual-slope PWM with TOP = 0xFF, and 101 is dual-slope PWM with TOP = compare A.
  - Single-slope and non-PWM counters step up and go to 0 in the cycle after TOP. The dual-slope counter climbs to TOP, then descends to 0, then climbs again.
- R4: In the non-PWM codes, a cycle whose count equals the active compare value changes the flip-flop at that clock edge. Action 01 inverts it, 10 clears it and 11 sets it.
- R5: In single-slope PWM, action 10 sets the flip-flop at the edge where the count equals TOP and clears it on a compare hit. Action 11 does the reverse. When both occur in the same cycle, the TOP action wins, so a compare value equal to TOP gives a constant level.
- R6: In dual-slope PWM, a hit whose next step goes up makes action 10 clear and action 11 set. A hit whose next step goes down does the reverse. A hit at TOP therefore counts as falling, so a compare value equal to TOP drives 1 under action 10, and a compare value of 0 drives 0.
- R7: In either PWM kind, action 01 on channel B disconnects the pin. On channel A it disconnects the pin while wave bit 2 is 0. When wave bit 2 is 1 it connects channel A, whose flip-flop then inverts on each compare hit.
- R8: In PWM codes, a compare write reaches the buffer only. The active value loads from the buffer at the edge where the count equals TOP. In non-PWM codes a write reaches the active value at the write edge.
- R9: Writing an action field never changes the output flip-flop. After reconnection the pin shows the level held since the last qualifying event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for wave code and action fields |
| cfg_wave | input | 3 | Wave code |
| cfg_fld_a | input | 2 | Action field, channel A |
| cfg_fld_b | input | 2 | Action field, channel B |
| cmp_a_we | input | 1 | Write strobe, compare A |
| cmp_a_val | input | CW | Compare A value |
| cmp_b_we | input | 1 | Write strobe, compare B |
| cmp_b_val | input | CW | Compare B value |
| port_data | input | 2 | Port data bits (bit 0 A, bit 1 B) |
| port_dir | input | 2 | Direction bits (bit 0 A, bit 1 B) |
| pin_a | output | 1 | Pin value, channel A |
| pin_b | output | 1 | Pin value, channel B |
| pin_oe | output | 2 | Pin driver enables |

## Verification
A register or compare write takes effect at the edge that captures it. The counter and both output flip-flops move at the edge whose pre-edge count produced the event, so a pin shows that event one full cycle after the cycle in which the count met the compare value. The port-data path is combinational and is visible in the same cycle. The bench drives every input between edges and steps its own behavioural model at each rising edge. It compares both pins and both enables at the following falling edge, and it places the hand-worked checks on the exact edge counts derived above.

// File: rtl/tc_pkg.sv
package tc_pkg;

  typedef enum logic [1:0] {
    WK_PLAIN = 2'd0,
    WK_FAST  = 2'd1,
    WK_DUAL  = 2'd2
  } wave_kind_e;

  // Counter behaviour class for a wave code.
  function automatic wave_kind_e kind_of(input logic [2:0] wave);
    if (!wave[0])     return WK_PLAIN;
    else if (wave[1]) return WK_FAST;
    else              return WK_DUAL;
  endfunction

  // TOP comes from compare A in the clear-on-compare code and in the
  // PWM codes that have bit 2 set.
  function automatic logic top_from_a(input logic [2:0] wave);
    return (wave == 3'b010) || (wave[2] && wave[0]);
  endfunction

  // Whether the flip-flop owns the pin.
  function automatic logic pin_connected(input wave_kind_e kind,
                                         input logic [1:0] fld,
                                         input logic       tog_ok);
    if (fld == 2'b00) return 1'b0;
    if (kind != WK_PLAIN && fld == 2'b01) return tog_ok;
    return 1'b1;
  endfunction

  // Next output flip-flop value for one channel.
  function automatic logic oc_next(input wave_kind_e kind,
                                   input logic [1:0] fld,
                                   input logic       tog_ok,
                                   input logic       hit,
                                   input logic       wrap,
                                   input logic       rising,
                                   input logic       cur);
    logic nx;
    nx = cur;
    unique case (kind)
      WK_PLAIN: begin
        if (hit) begin
          case (fld)
            2'b01:   nx = ~cur;
            2'b10:   nx = 1'b0;
            2'b11:   nx = 1'b1;
            default: nx = cur;
          endcase
        end
      end
      WK_FAST: begin
        case (fld)
          2'b01:   if (tog_ok && hit) nx = ~cur;
          2'b10:   if (wrap) nx = 1'b1; else if (hit) nx = 1'b0;
          2'b11:   if (wrap) nx = 1'b0; else if (hit) nx = 1'b1;
          default: nx = cur;
        endcase
      end
      default: begin
        case (fld)
          2'b01:   if (tog_ok && hit) nx = ~cur;
          2'b10:   if (hit) nx = ~rising;
          2'b11:   if (hit) nx = rising;
          default: nx = cur;
        endcase
      end
    endcase
    return nx;
  endfunction

endpackage

// File: rtl/tc_count.sv
module tc_count
  import tc_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  wave_kind_e    kind,
  input  logic [CW-1:0] top,
  output logic [CW-1:0] cnt,
  output logic          at_top,
  output logic          rising
);

  localparam logic [CW-1:0] ONE = CW'(1);

  logic          up_q;
  logic          up_d;
  logic [CW-1:0] cnt_d;

  // Direction of the step the counter takes next.
  function automatic logic next_goes_up(input logic [CW-1:0] c,
                                        input logic          up,
                                        input logic [CW-1:0] t);
    return up ? (c < t) : (c == '0);
  endfunction

  assign at_top = (cnt == top);
  assign rising = (kind == WK_DUAL) ? next_goes_up(cnt, up_q, top) : 1'b1;

  always_comb begin
    cnt_d = cnt;
    up_d  = up_q;
    if (kind == WK_DUAL) begin
      if (top == '0) begin
        cnt_d = '0;
        up_d  = 1'b1;
      end else if (up_q) begin
        if (cnt >= top) begin
          cnt_d = cnt - ONE;
          up_d  = 1'b0;
        end else begin
          cnt_d = cnt + ONE;
        end
      end else if (cnt == '0) begin
        cnt_d = ONE;
        up_d  = 1'b1;
      end else begin
        cnt_d = cnt - ONE;
      end
    end else begin
      up_d  = 1'b1;
      cnt_d = at_top ? '0 : cnt + ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      up_q <= 1'b1;
    end else begin
      cnt  <= cnt_d;
      up_q <= up_d;
    end
  end

  AST_FAST_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == WK_FAST && at_top) |=> (cnt == '0)); // R3
  AST_DUAL_TURN: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == WK_DUAL && up_q && at_top && top != '0) |=> (cnt == CW'($past(cnt) - ONE))); // R3

endmodule

// File: rtl/tc_oc_chan.sv
module tc_oc_chan
  import tc_pkg::*;
#(
  parameter int CW      = 8,
  parameter bit HAS_TOG = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  wave_kind_e    kind,
  input  logic          wave_hi,
  input  logic [1:0]    fld,
  input  logic          wr_en,
  input  logic [CW-1:0] wr_val,
  input  logic [CW-1:0] cnt,
  input  logic          at_top,
  input  logic          rising,
  input  logic          port_bit,
  output logic [CW-1:0] cmp_act,
  output logic          pin
);

  logic [CW-1:0] buf_q;
  logic [CW-1:0] act_q;
  logic          oc_q;

  // Named internal events.
  logic hit;
  logic load_ev;
  logic tog_ok;
  logic conn;

  assign tog_ok  = HAS_TOG && wave_hi;
  assign hit     = (cnt == act_q);
  assign load_ev = (kind != WK_PLAIN) && at_top;
  assign conn    = pin_connected(kind, fld, tog_ok);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q <= '0;
      act_q <= '0;
      oc_q  <= 1'b0;
    end else begin
      if (wr_en) buf_q <= wr_val;
      if (kind == WK_PLAIN) begin
        if (wr_en) act_q <= wr_val;
      end else if (load_ev) begin
        act_q <= buf_q;
      end
      oc_q <= oc_next(kind, fld, tog_ok, hit, at_top, rising, oc_q);
    end
  end

  assign cmp_act = act_q;
  assign pin     = conn ? oc_q : port_bit;

  AST_BUF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (kind != WK_PLAIN && !at_top) |=> $stable(act_q)); // R8
  AST_OC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit && !at_top) |=> $stable(oc_q)); // R9
  AST_TOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == WK_FAST && fld == 2'b10 && at_top) |=> oc_q); // R5
  AST_DUAL_FALL_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == WK_DUAL && fld == 2'b10 && hit && !rising) |=> oc_q); // R6

endmodule

// File: rtl/tc_pwm_unit.sv
module tc_pwm_unit
  import tc_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_wave,
  input  logic [1:0]    cfg_fld_a,
  input  logic [1:0]    cfg_fld_b,
  input  logic          cmp_a_we,
  input  logic [CW-1:0] cmp_a_val,
  input  logic          cmp_b_we,
  input  logic [CW-1:0] cmp_b_val,
  input  logic [1:0]    port_data,
  input  logic [1:0]    port_dir,
  output logic          pin_a,
  output logic          pin_b,
  output logic [1:0]    pin_oe
);

  localparam int NCH = 2;

  logic [2:0]    wave_q;
  logic [1:0]    fld_q  [NCH];
  logic [1:0]    fld_in [NCH];
  logic [CW-1:0] wr_val [NCH];
  logic [CW-1:0] act    [NCH];
  logic [NCH-1:0] wr_en;
  logic [NCH-1:0] pin_w;

  wave_kind_e    kind;
  logic [CW-1:0] top;
  logic [CW-1:0] cnt;
  logic          at_top;
  logic          rising;

  assign fld_in[0] = cfg_fld_a;
  assign fld_in[1] = cfg_fld_b;
  assign wr_val[0] = cmp_a_val;
  assign wr_val[1] = cmp_b_val;
  assign wr_en     = {cmp_b_we, cmp_a_we};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wave_q <= 3'b000;
      for (int i = 0; i < NCH; i++) fld_q[i] <= 2'b00;
    end else if (cfg_we) begin
      wave_q <= cfg_wave;
      for (int i = 0; i < NCH; i++) fld_q[i] <= fld_in[i];
    end
  end

  assign kind = kind_of(wave_q);
  assign top  = top_from_a(wave_q) ? act[0] : '1;

  tc_count #(.CW(CW)) u_count (
    .clk    (clk),
    .rst_n  (rst_n),
    .kind   (kind),
    .top    (top),
    .cnt    (cnt),
    .at_top (at_top),
    .rising (rising)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    tc_oc_chan #(.CW(CW), .HAS_TOG(g == 0)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .kind     (kind),
      .wave_hi  (wave_q[2]),
      .fld      (fld_q[g]),
      .wr_en    (wr_en[g]),
      .wr_val   (wr_val[g]),
      .cnt      (cnt),
      .at_top   (at_top),
      .rising   (rising),
      .port_bit (port_data[g]),
      .cmp_act  (act[g]),
      .pin      (pin_w[g])
    );
  end

  assign pin_a  = pin_w[0];
  assign pin_b  = pin_w[1];
  assign pin_oe = port_dir;

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(wave_q)); // R3

endmodule

// File: tb/tb_tc_pwm_unit.sv
module tb_tc_pwm_unit;

  localparam int CW   = 8;
  localparam int NVEC = 15;
  localparam int RUN  = 600;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [2:0]    cfg_wave = '0;
  logic [1:0]    cfg_fld_a = '0;
  logic [1:0]    cfg_fld_b = '0;
  logic          cmp_a_we = 1'b0;
  logic [CW-1:0] cmp_a_val = '0;
  logic          cmp_b_we = 1'b0;
  logic [CW-1:0] cmp_b_val = '0;
  logic [1:0]    port_data = '0;
  logic [1:0]    port_dir = '0;
  logic          pin_a, pin_b;
  logic [1:0]    pin_oe;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  tc_pwm_unit #(.CW(CW)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wave(cfg_wave),
    .cfg_fld_a(cfg_fld_a), .cfg_fld_b(cfg_fld_b),
    .cmp_a_we(cmp_a_we), .cmp_a_val(cmp_a_val),
    .cmp_b_we(cmp_b_we), .cmp_b_val(cmp_b_val),
    .port_data(port_data), .port_dir(port_dir),
    .pin_a(pin_a), .pin_b(pin_b), .pin_oe(pin_oe)
  );

  // Stimulus rows: {wave[3], field A[2], field B[2], compare A[8], compare B[8]}
  localparam logic [22:0] VEC [NVEC] = '{
    {3'b000, 2'b01, 2'b10, 8'h10, 8'h80},
    {3'b000, 2'b11, 2'b01, 8'h00, 8'hFF},
    {3'b010, 2'b01, 2'b11, 8'h07, 8'h03},
    {3'b010, 2'b10, 2'b01, 8'h00, 8'h00},
    {3'b011, 2'b10, 2'b11, 8'h40, 8'hC0},
    {3'b011, 2'b11, 2'b10, 8'h00, 8'hFF},
    {3'b011, 2'b01, 2'b01, 8'h20, 8'h20},
    {3'b111, 2'b01, 2'b10, 8'h30, 8'h10},
    {3'b111, 2'b10, 2'b11, 8'h30, 8'h30},
    {3'b001, 2'b10, 2'b11, 8'h80, 8'h00},
    {3'b001, 2'b11, 2'b10, 8'hFF, 8'hFF},
    {3'b101, 2'b01, 2'b10, 8'h50, 8'h20},
    {3'b101, 2'b10, 2'b11, 8'h50, 8'h50},
    {3'b100, 2'b01, 2'b11, 8'h33, 8'h44},
    {3'b110, 2'b10, 2'b01, 8'h00, 8'h80}
  };

  // Behavioural model state
  logic [7:0] m_cnt;
  logic       m_up;
  logic [2:0] m_wave;
  logic [1:0] m_fld [2];
  logic [7:0] m_buf [2];
  logic [7:0] m_act [2];
  logic       m_oc  [2];

  int  mm_count;
  bit  mm_seen;
  logic [3:0] mm_got, mm_exp;

  task automatic chk(input bit ok, input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic model_reset();
    m_cnt = 0; m_up = 1; m_wave = 0;
    for (int c = 0; c < 2; c++) begin
      m_fld[c] = 0; m_buf[c] = 0; m_act[c] = 0; m_oc[c] = 0;
    end
  endtask

  // 0 plain, 1 single slope, 2 dual slope
  function automatic int mode_class(input logic [2:0] w);
    case (w)
      3'b001, 3'b101: return 2;
      3'b011, 3'b111: return 1;
      default:        return 0;
    endcase
  endfunction

  function automatic bit drives_pin(input int ch);
    int k = mode_class(m_wave);
    if (m_fld[ch] == 2'b00) return 0;
    if (m_fld[ch] == 2'b01 && k != 0) return (ch == 0) && m_wave[2];
    return 1;
  endfunction

  task automatic model_step();
    int k;
    logic [7:0] top;
    bit wrap, up_next;
    logic [7:0] old_buf [2];
    k = mode_class(m_wave);
    top = (m_wave == 3'b010 || m_wave == 3'b101 || m_wave == 3'b111) ? m_act[0] : 8'hFF;
    wrap = (m_cnt == top);
    if (k == 2) up_next = m_up ? (m_cnt < top) : (m_cnt == 0);
    else        up_next = 1;
    for (int c = 0; c < 2; c++) begin
      bit hit = (m_cnt == m_act[c]);
      bit tog = (c == 0) && m_wave[2];
      if (k == 0) begin
        if (hit && m_fld[c] == 2'b01) m_oc[c] = !m_oc[c];
        if (hit && m_fld[c] == 2'b10) m_oc[c] = 0;
        if (hit && m_fld[c] == 2'b11) m_oc[c] = 1;
      end else if (m_fld[c] == 2'b01) begin
        if (tog && hit) m_oc[c] = !m_oc[c];
      end else if (k == 1) begin
        if (m_fld[c] == 2'b10) m_oc[c] = wrap ? 1'b1 : (hit ? 1'b0 : m_oc[c]);
        if (m_fld[c] == 2'b11) m_oc[c] = wrap ? 1'b0 : (hit ? 1'b1 : m_oc[c]);
      end else if (hit) begin
        if (m_fld[c] == 2'b10) m_oc[c] = up_next ? 1'b0 : 1'b1;
        if (m_fld[c] == 2'b11) m_oc[c] = up_next ? 1'b1 : 1'b0;
      end
    end
    if (k == 2) begin
      if (top == 0) begin m_cnt = 0; m_up = 1; end
      else if (m_up && m_cnt >= top) begin m_cnt = m_cnt - 1; m_up = 0; end
      else if (m_up) m_cnt = m_cnt + 1;
      else if (m_cnt == 0) begin m_cnt = 1; m_up = 1; end
      else m_cnt = m_cnt - 1;
    end else begin
      m_up = 1;
      m_cnt = wrap ? 8'h00 : m_cnt + 8'h01;
    end
    old_buf[0] = m_buf[0]; old_buf[1] = m_buf[1];
    if (cmp_a_we) m_buf[0] = cmp_a_val;
    if (cmp_b_we) m_buf[1] = cmp_b_val;
    if (k == 0) begin
      if (cmp_a_we) m_act[0] = cmp_a_val;
      if (cmp_b_we) m_act[1] = cmp_b_val;
    end else if (wrap) begin
      m_act[0] = old_buf[0]; m_act[1] = old_buf[1];
    end
    if (cfg_we) begin
      m_wave = cfg_wave; m_fld[0] = cfg_fld_a; m_fld[1] = cfg_fld_b;
    end
  endtask

  task automatic model_compare();
    logic ea, eb;
    ea = drives_pin(0) ? m_oc[0] : port_data[0];
    eb = drives_pin(1) ? m_oc[1] : port_data[1];
    if (pin_a !== ea || pin_b !== eb || pin_oe !== port_dir) begin
      mm_count++;
      if (!mm_seen) begin
        mm_seen = 1;
        mm_got = {pin_oe, pin_b, pin_a};
        mm_exp = {port_dir, eb, ea};
      end
    end
  endtask

  task automatic tick();
    model_step();
    @(posedge clk);
    #1;
    cfg_we = 0; cmp_a_we = 0; cmp_b_we = 0;
    @(negedge clk);
    model_compare();
  endtask

  task automatic mm_clear();
    mm_count = 0; mm_seen = 0; mm_got = 0; mm_exp = 0;
  endtask

  task automatic run_compare(input int n, input string req);
    for (int i = 0; i < n; i++) tick();
    chk(mm_count == 0, req, {4'h0, mm_got}, {4'h0, mm_exp});
    mm_clear();
  endtask

  task automatic do_reset();
    rst_n = 0;
    model_reset();
    repeat (2) @(negedge clk);
    rst_n = 1;
    mm_clear();
  endtask

  function automatic string tag_of(input logic [2:0] w);
    case (mode_class(w))
      1:       return "R3 R5 R7 R8";
      2:       return "R3 R6 R7 R8";
      default: return "R3 R4";
    endcase
  endfunction

  initial begin
    #(10 * 200000);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // Reset state, R1 and R2
    port_data = 2'b10; port_dir = 2'b01;
    rst_n = 0;
    model_reset();
    @(negedge clk);
    chk(pin_a == 1'b0 && pin_b == 1'b1 && pin_oe == 2'b01, "R1 R2 reset pins",
        {5'h0, pin_oe, pin_b}, 8'h03);
    do_reset();

    // R4: set on hit at count 5 in free-running code
    port_data = 2'b00; port_dir = 2'b11;
    cfg_we = 1; cfg_wave = 3'b000; cfg_fld_a = 2'b11; cfg_fld_b = 2'b00;
    cmp_a_we = 1; cmp_a_val = 8'd5;
    tick();
    repeat (4) tick();
    chk(pin_a == 1'b0, "R4 before hit", {7'h0, pin_a}, 8'h00);
    tick();
    chk(pin_a == 1'b1, "R4 after hit", {7'h0, pin_a}, 8'h01);

    // R9 and R2: disconnect, pass-through, reconnect keeps level
    cfg_we = 1; cfg_fld_a = 2'b00;
    tick();
    chk(pin_a == 1'b0, "R2 R9 disconnected shows port", {7'h0, pin_a}, 8'h00);
    port_data = 2'b01;
    #1;
    chk(pin_a == 1'b1, "R2 same-cycle port follow", {7'h0, pin_a}, 8'h01);
    port_data = 2'b00;
    cfg_we = 1; cfg_fld_a = 2'b10;
    tick();
    chk(pin_a == 1'b1, "R9 flop held across field write", {7'h0, pin_a}, 8'h01);
    mm_clear();
    run_compare(300, "R4 R9 model");

    // R8: buffered compare write in single-slope PWM
    do_reset();
    port_dir = 2'b10;
    cfg_we = 1; cfg_wave = 3'b011; cfg_fld_a = 2'b00; cfg_fld_b = 2'b10;
    cmp_b_we = 1; cmp_b_val = 8'h10;
    tick();
    repeat (40) tick();
    cmp_b_we = 1; cmp_b_val = 8'h80;
    tick();
    run_compare(600, "R8 buffered load");

    // Vector table
    for (int v = 0; v < NVEC; v++) begin
      logic [22:0] row;
      row = VEC[v];
      do_reset();
      port_data = v[1:0]; port_dir = ~v[1:0];
      cfg_we = 1; cfg_wave = row[22:20]; cfg_fld_a = row[19:18]; cfg_fld_b = row[17:16];
      cmp_a_we = 1; cmp_a_val = row[15:8];
      cmp_b_we = 1; cmp_b_val = row[7:0];
      tick();
      run_compare(RUN, tag_of(row[22:20]));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule